// File: doc/BRIEF.md
# Active Stereo Eye Alternation Controller

This block sequences frame-alternating stereo output. The left and right views sit side by side in a single frame buffer that is twice as wide as the visible screen. Once per frame, during vertical blanking, the block moves the scan-out start address to the origin of the other half. It also produces a one-bit shutter-glasses control whose edge is placed a programmable number of pixel clocks before the next frame's first active pixel. That placement does not depend on when the address moves.

The block runs on the pixel clock. A video timing generator elsewhere supplies the pixel and line position and a one-cycle pulse at the start of vertical blanking. The position counters read x=0, y=0 on the first active pixel of a frame, and a frame lasts h_total × v_total clocks. The lead time is converted continuously into a line/pixel compare point by a serial divider. A new lead value therefore reaches the compare point within about 2·(LEAD_W+2) clocks. After a change to the lead, one full frame must pass before the shutter and eye relationship is settled.

Top module: `stereo_eye_ctrl`

## Requirements
- R1: While rst is high and in the first cycle after it falls, eye_o is 0 (left view), shutter_o is at its left-open level (0 with the default polarity), and start_addr_o equals base_addr_i.
- R2: eye_o inverts in the clock cycle after each cycle in which vblank_start_i is high, and at no other time.
- R3: On that same edge, start_addr_o takes the origin of the view being entered: base_addr_i when eye_o becomes 0, and base_addr_i + half_width_i when eye_o becomes 1.
- R4: start_addr_o does not change in any cycle other than the one following a vblank_start_i pulse.
- R5: The lead must lie in 1 … h_total·v_total−1. Let P = h_total·v_total − lead. shutter_o changes one clock after the counters present y = P / h_total, x = P mod h_total. It changes at most once per frame, and it takes the eye value of the frame that follows the retrace (0 = left, 1 = right, default polarity).
- R6: A lead of 0 behaves as a lead of 1, so the edge follows the last position of the frame (y = v_total−1, x = h_total−1).
- R7: When the lead has been stable for a whole frame, shutter_o equals eye_o whenever the counters present the first active pixel (x=0, y=0).
- R8: A change to base_addr_i or half_width_i made during active video has no effect on start_addr_o until the next vblank_start_i pulse, which then uses the new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| vblank_start_i | input | 1 | One-cycle pulse at the first blanking line |
| pix_x_i | input | H_W | Pixel position within the line, 0 at first active pixel |
| pix_y_i | input | V_W | Line position within the frame, 0 at first active line |
| h_total_i | input | H_W | Clocks per line including blanking |
| v_total_i | input | V_W | Lines per frame including blanking |
| base_addr_i | input | ADDR_W | Origin of the left half of the frame buffer |
| half_width_i | input | ADDR_W | Visible width in bytes (offset to the right half) |
| lead_i | input | LEAD_W | Shutter lead time in pixel clocks before active video |
| start_addr_o | output | ADDR_W | Current scan-out start address |
| eye_o | output | 1 | View being scanned out, 0 left, 1 right |
| shutter_o | output | 1 | Shutter-glasses control bit |

## Verification
The hardest case to reach is a shutter edge that falls before the blanking pulse or straddles the frame wrap. There the glasses must already announce the next eye while the address still shows the current one. A short lead cannot produce this. The bench drives small geometries (16 × 10 clocks) and sweeps the lead so that the compare point lands after the blanking pulse, before it on a line boundary, on the last pixel (lead 0), and on the second pixel of the next frame. It lets two unchecked frames settle after each lead change. A scoreboard then matches every output change against the position at which the requirements place it.

// File: rtl/stereo_pkg.sv
`timescale 1ns/1ps
package stereo_pkg;
  typedef enum logic [1:0] {
    DIV_LOAD = 2'd0,
    DIV_RUN  = 2'd1,
    DIV_POST = 2'd2
  } div_state_e;

  typedef enum logic {
    EYE_LEFT  = 1'b0,
    EYE_RIGHT = 1'b1
  } eye_e;
endpackage

// File: rtl/stereo_lead_div.sv
`timescale 1ns/1ps
// Serial restoring divider: turns a lead time in pixel clocks into the
// line/pixel position at which the shutter must switch. It reruns forever,
// so a new lead is reflected within two conversions.
module stereo_lead_div
  import stereo_pkg::*;
#(
  parameter int H_W    = 12,
  parameter int V_W    = 11,
  parameter int LEAD_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LEAD_W-1:0] lead_i,
  input  logic [H_W-1:0]    h_total_i,
  input  logic [V_W-1:0]    v_total_i,
  output logic [H_W-1:0]    cmp_x_o,
  output logic [V_W-1:0]    cmp_y_o,
  output logic              cmp_valid_o
);
  localparam int CNT_W = $clog2(LEAD_W + 1);

  div_state_e        state_q;
  logic [LEAD_W-1:0] dvd_q;
  logic [LEAD_W-1:0] quo_q;
  logic [H_W-1:0]    dsr_q;
  logic [H_W-1:0]    rem_q;
  logic [V_W-1:0]    vt_q;
  logic [CNT_W-1:0]  cnt_q;

  logic [LEAD_W-1:0] lead_eff;
  logic [H_W:0]      rem_shift;
  logic              fits;
  logic [V_W-1:0]    quo_lines;

  assign lead_eff  = (lead_i == '0) ? LEAD_W'(1) : lead_i;
  assign rem_shift = {rem_q, dvd_q[LEAD_W-1]};
  assign fits      = (rem_shift >= {1'b0, dsr_q});
  assign quo_lines = V_W'(quo_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= DIV_LOAD;
      dvd_q       <= '0;
      quo_q       <= '0;
      dsr_q       <= '0;
      rem_q       <= '0;
      vt_q        <= '0;
      cnt_q       <= '0;
      cmp_x_o     <= '0;
      cmp_y_o     <= '0;
      cmp_valid_o <= 1'b0;
    end else begin
      unique case (state_q)
        DIV_LOAD: begin
          dvd_q   <= lead_eff;
          dsr_q   <= h_total_i;
          vt_q    <= v_total_i;
          rem_q   <= '0;
          quo_q   <= '0;
          cnt_q   <= CNT_W'(LEAD_W);
          state_q <= DIV_RUN;
        end
        DIV_RUN: begin
          dvd_q <= {dvd_q[LEAD_W-2:0], 1'b0};
          quo_q <= {quo_q[LEAD_W-2:0], fits};
          if (fits) rem_q <= H_W'(rem_shift - {1'b0, dsr_q});
          else      rem_q <= H_W'(rem_shift);
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == CNT_W'(1)) state_q <= DIV_POST;
        end
        DIV_POST: begin
          if (rem_q == '0) begin
            cmp_y_o <= vt_q - quo_lines;
            cmp_x_o <= '0;
          end else begin
            cmp_y_o <= vt_q - quo_lines - 1'b1;
            cmp_x_o <= dsr_q - rem_q;
          end
          cmp_valid_o <= 1'b1;
          state_q     <= DIV_LOAD;
        end
        default: state_q <= DIV_LOAD;
      endcase
    end
  end
endmodule

// File: rtl/stereo_addr_sel.sv
`timescale 1ns/1ps
// Eye state and scan-out origin. A shadow register holds the origin of the
// view that comes next; it is committed on the blanking pulse only.
module stereo_addr_sel
  import stereo_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vblank_start_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic [ADDR_W-1:0] half_width_i,
  output logic [ADDR_W-1:0] start_addr_o,
  output logic              eye_o
);
  eye_e              eye_q;
  logic [ADDR_W-1:0] shadow_q;
  logic [ADDR_W-1:0] right_origin;

  assign right_origin = base_addr_i + half_width_i;
  assign eye_o        = eye_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      eye_q        <= EYE_LEFT;
      start_addr_o <= base_addr_i;
      shadow_q     <= right_origin;
    end else begin
      shadow_q <= (eye_q == EYE_LEFT) ? right_origin : base_addr_i;
      if (vblank_start_i) begin
        eye_q        <= (eye_q == EYE_LEFT) ? EYE_RIGHT : EYE_LEFT;
        start_addr_o <= shadow_q;
      end
    end
  end
endmodule

// File: rtl/stereo_shutter_gen.sv
`timescale 1ns/1ps
// Shutter edge placement: switches once per frame at the compare point to
// the eye that follows the current frame.
module stereo_shutter_gen #(
  parameter int H_W = 12,
  parameter int V_W = 11
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [H_W-1:0] pix_x_i,
  input  logic [V_W-1:0] pix_y_i,
  input  logic [H_W-1:0] cmp_x_i,
  input  logic [V_W-1:0] cmp_y_i,
  input  logic           cmp_valid_i,
  input  logic           eye_i,
  output logic           shutter_o
);
  logic frame_eye_q;
  logic armed_q;
  logic frame_start;
  logic hit;

  assign frame_start = (pix_x_i == '0) && (pix_y_i == '0);
  assign hit         = cmp_valid_i && (pix_x_i == cmp_x_i) && (pix_y_i == cmp_y_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      shutter_o   <= 1'b0;
      frame_eye_q <= 1'b0;
      armed_q     <= 1'b1;
    end else begin
      if (frame_start) begin
        frame_eye_q <= eye_i;
        armed_q     <= 1'b1;
      end else if (hit && armed_q) begin
        shutter_o <= ~frame_eye_q;
        armed_q   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/stereo_eye_ctrl.sv
`timescale 1ns/1ps
module stereo_eye_ctrl #(
  parameter int H_W           = 12,
  parameter int V_W           = 11,
  parameter int LEAD_W        = 20,
  parameter int ADDR_W        = 32,
  parameter bit SHUT_LEFT_LVL = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vblank_start_i,
  input  logic [H_W-1:0]    pix_x_i,
  input  logic [V_W-1:0]    pix_y_i,
  input  logic [H_W-1:0]    h_total_i,
  input  logic [V_W-1:0]    v_total_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic [ADDR_W-1:0] half_width_i,
  input  logic [LEAD_W-1:0] lead_i,
  output logic [ADDR_W-1:0] start_addr_o,
  output logic              eye_o,
  output logic              shutter_o
);
  logic [H_W-1:0] cmp_x;
  logic [V_W-1:0] cmp_y;
  logic           cmp_valid;
  logic           shutter_raw;

  stereo_lead_div #(.H_W(H_W), .V_W(V_W), .LEAD_W(LEAD_W)) u_div (
    .clk         (clk),
    .rst         (rst),
    .lead_i      (lead_i),
    .h_total_i   (h_total_i),
    .v_total_i   (v_total_i),
    .cmp_x_o     (cmp_x),
    .cmp_y_o     (cmp_y),
    .cmp_valid_o (cmp_valid)
  );

  stereo_addr_sel #(.ADDR_W(ADDR_W)) u_addr (
    .clk            (clk),
    .rst            (rst),
    .vblank_start_i (vblank_start_i),
    .base_addr_i    (base_addr_i),
    .half_width_i   (half_width_i),
    .start_addr_o   (start_addr_o),
    .eye_o          (eye_o)
  );

  stereo_shutter_gen #(.H_W(H_W), .V_W(V_W)) u_shut (
    .clk         (clk),
    .rst         (rst),
    .pix_x_i     (pix_x_i),
    .pix_y_i     (pix_y_i),
    .cmp_x_i     (cmp_x),
    .cmp_y_i     (cmp_y),
    .cmp_valid_i (cmp_valid),
    .eye_i       (eye_o),
    .shutter_o   (shutter_raw)
  );

  generate
    if (SHUT_LEFT_LVL) begin : g_shut_inv
      assign shutter_o = ~shutter_raw;
    end else begin : g_shut_pass
      assign shutter_o = shutter_raw;
    end
  endgenerate
endmodule

// File: rtl/stereo_eye_ctrl_chk.sv
`timescale 1ns/1ps
module stereo_eye_ctrl_chk #(
  parameter int ADDR_W        = 32,
  parameter bit SHUT_LEFT_LVL = 1'b0
) (
  input logic              clk,
  input logic              rst,
  input logic              vblank_start_i,
  input logic [ADDR_W-1:0] base_addr_i,
  input logic [ADDR_W-1:0] half_width_i,
  input logic [ADDR_W-1:0] start_addr_o,
  input logic              eye_o,
  input logic              shutter_o
);
  assert_reset_left_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!eye_o && (shutter_o == SHUT_LEFT_LVL) && (start_addr_o == $past(base_addr_i))));

  assert_eye_flips_R2: assert property (@(posedge clk) disable iff (rst)
    vblank_start_i |=> (eye_o != $past(eye_o)));

  assert_eye_only_on_blank_R2: assert property (@(posedge clk) disable iff (rst)
    (eye_o != $past(eye_o)) |-> $past(vblank_start_i));

  assert_origin_pick_R3: assert property (@(posedge clk) disable iff (rst)
    (vblank_start_i && $stable(base_addr_i) && $stable(half_width_i)) |=>
      (start_addr_o == (eye_o ? ($past(base_addr_i) + $past(half_width_i)) : $past(base_addr_i))));

  assert_addr_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (start_addr_o != $past(start_addr_o)) |-> ($past(vblank_start_i) || $past(rst)));
endmodule

bind stereo_eye_ctrl stereo_eye_ctrl_chk #(.ADDR_W(ADDR_W), .SHUT_LEFT_LVL(SHUT_LEFT_LVL)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .vblank_start_i (vblank_start_i),
  .base_addr_i    (base_addr_i),
  .half_width_i   (half_width_i),
  .start_addr_o   (start_addr_o),
  .eye_o          (eye_o),
  .shutter_o      (shutter_o)
);

// File: tb/stereo_eye_ctrl_bench.sv
`timescale 1ns/1ps
module stereo_eye_ctrl_bench;
  localparam int H_W = 12, V_W = 11, LEAD_W = 20, ADDR_W = 32;
  localparam int H_TOT = 16, V_TOT = 10, VB_LINE = 8;
  localparam int TOT = H_TOT * V_TOT;

  typedef struct {
    int          kind;   // 0 eye, 1 address, 2 shutter
    logic [31:0] val;
    int          y;
    int          x;
    string       req;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic              vb = 1'b0;
  logic [H_W-1:0]    pix_x = '0;
  logic [V_W-1:0]    pix_y = '0;
  logic [ADDR_W-1:0] base = 32'h0000_1000;
  logic [ADDR_W-1:0] width = 32'h0000_0A00;
  logic [LEAD_W-1:0] lead = 20'd20;
  logic [ADDR_W-1:0] start_addr;
  logic              eye, shutter;

  exp_t q[$];
  int   n_chk = 0, n_bad = 0;
  bit   mon_en = 1'b0, done = 1'b0;
  bit   exp_eye = 1'b0;
  logic p_eye, p_sh;
  logic [ADDR_W-1:0] p_addr;

  always #2 clk = ~clk;

  stereo_eye_ctrl #(.H_W(H_W), .V_W(V_W), .LEAD_W(LEAD_W), .ADDR_W(ADDR_W)) u_stereo_eye_ctrl (
    .clk(clk), .rst(rst), .vblank_start_i(vb), .pix_x_i(pix_x), .pix_y_i(pix_y),
    .h_total_i(H_W'(H_TOT)), .v_total_i(V_W'(V_TOT)), .base_addr_i(base),
    .half_width_i(width), .lead_i(lead), .start_addr_o(start_addr),
    .eye_o(eye), .shutter_o(shutter)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_event(input int kind, input logic [31:0] val);
    exp_t it;
    string rq;
    rq = (kind == 0) ? "R2" : (kind == 1) ? "R4" : "R5";
    if (q.size() == 0) begin
      check(1'b0, rq, $sformatf("unexpected change kind %0d at y=%0d x=%0d", kind, pix_y, pix_x),
            val, 32'hFFFF_FFFF);
    end else begin
      it = q.pop_front();
      check(it.kind == kind, it.req, "event kind", 32'(kind), 32'(it.kind));
      check(it.val == val, it.req, "event value", val, it.val);
      check(it.y == int'(pix_y) && it.x == int'(pix_x), it.req, "event position (y*256+x)",
            32'(int'(pix_y) * 256 + int'(pix_x)), 32'(it.y * 256 + it.x));
    end
  endtask

  // monitor: samples 1 ns after each rising edge, inputs still as latched
  always begin
    @(posedge clk);
    #1;
    if (mon_en) begin
      if (eye != p_eye)         chk_event(0, 32'(eye));
      if (start_addr != p_addr) chk_event(1, start_addr);
      if (shutter != p_sh)      chk_event(2, 32'(shutter));
      if (pix_x == '0 && pix_y == '0) begin
        check(shutter == eye, "R7", "shutter vs eye at active start", 32'(shutter), 32'(eye));
        check(eye == exp_eye, "R2", "eye at active start", 32'(eye), 32'(exp_eye));
      end
    end
    p_eye  = eye;
    p_addr = start_addr;
    p_sh   = shutter;
  end

  task automatic push_frame(input string sh_req, input string ad_req);
    exp_t e_eye, e_adr, e_sh;
    int le, tgt, vbi;
    bit nxt;
    nxt = ~exp_eye;
    le  = (lead == '0) ? 1 : int'(lead);
    tgt = TOT - le;
    vbi = VB_LINE * H_TOT;
    e_eye = '{0, 32'(nxt), VB_LINE, 0, "R2"};
    e_adr = '{1, nxt ? base + width : base, VB_LINE, 0, ad_req};
    e_sh  = '{2, 32'(nxt), tgt / H_TOT, tgt % H_TOT, sh_req};
    if (tgt < vbi) q.push_back(e_sh);
    q.push_back(e_eye);
    q.push_back(e_adr);
    if (tgt > vbi) q.push_back(e_sh);
  endtask

  task automatic end_check();
    check(q.size() == 0, "R5", "events left unseen in frame", 32'(q.size()), 32'd0);
    q.delete();
  endtask

  task automatic frame(input bit chk, input string sh_req, input string ad_req);
    @(negedge clk);
    if (mon_en) end_check();
    if (chk) push_frame(sh_req, ad_req);
    mon_en = chk;
    for (int i = 0; i < TOT; i++) begin
      if (i != 0) @(negedge clk);
      pix_y = V_W'(i / H_TOT);
      pix_x = H_W'(i % H_TOT);
      vb    = (i / H_TOT == VB_LINE) && (i % H_TOT == 0);
    end
    exp_eye = ~exp_eye;
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    pix_x = H_W'(5);
    pix_y = V_W'(3);
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #1;
    check(eye == 1'b0, "R1", "eye after reset", 32'(eye), 32'd0);
    check(shutter == 1'b0, "R1", "shutter after reset", 32'(shutter), 32'd0);
    check(start_addr == base, "R1", "start address after reset", start_addr, base);
    repeat (40) @(negedge clk);

    // lead 20: compare point after the blanking pulse
    for (int f = 0; f < 3; f++) frame(1'b1, "R5", "R3");

    // new base / width applied at frame start, committed at next blank
    base = 32'h0000_8000;
    frame(1'b1, "R5", "R8");
    frame(1'b1, "R5", "R8");
    width = 32'h0000_0400;
    frame(1'b1, "R5", "R8");

    // lead 48: compare point on a line boundary before the blanking pulse
    lead = 20'd48;
    frame(1'b0, "", ""); frame(1'b0, "", "");
    frame(1'b1, "R5", "R3"); frame(1'b1, "R5", "R3");

    // lead 0 behaves as 1: last position of the frame
    lead = 20'd0;
    frame(1'b0, "", ""); frame(1'b0, "", "");
    frame(1'b1, "R6", "R3"); frame(1'b1, "R6", "R3");

    // largest lead: edge on the second pixel of the frame
    lead = 20'(TOT - 1);
    frame(1'b0, "", ""); frame(1'b0, "", "");
    frame(1'b1, "R5", "R3"); frame(1'b1, "R5", "R3");

    @(negedge clk);
    end_check();
    mon_en = 1'b0;
    done = 1'b1;
    summary();
    $finish;
  end
endmodule